// File: doc/BRIEF.md
# Deferred-Burst DRAM Refresh Scheduler

This block decides when a DDR memory controller must spend a cycle on refresh. A free-running interval timer produces one refresh obligation per period. The period is chosen with a 2-bit select to suit the controller clock. Obligations go into a small saturating counter of owed refreshes. The command sequencer pays them back one at a time by pulsing a completion input.

When deferral is enabled, owed refreshes wait behind memory traffic. A request is shown only while the request arbiter reports idle. Once enough refreshes are owed, the request turns urgent and must be served ahead of memory accesses. This keeps refresh from stalling accesses or closing open pages early, without letting the devices go unrefreshed. When deferral is off, any owed refresh is requested at once.

A debug-only disable input stops all refresh generation. The storage that drives this input is expected to sit outside the block and survive system reset. The block therefore never forces refresh back on by itself.

Top module: `refresh_sched`

## Requirements
- R1: While reset is asserted and just after it is released, the pending count is 0 and both the request and urgent outputs are low.
- R2: The interval select maps code 0 to 1560, code 1 to 1170, code 2 to 780 and code 3 to 390 clocks. With refresh enabled from reset release, the pending count first becomes 1 exactly that many rising edges later.
- R3: Each interval tick adds one to the pending count and each completion pulse removes one. A tick and a completion on the same edge leave the count unchanged.
- R4: The pending count saturates at 4. A tick arriving with 4 already owed leaves it at 4.
- R5: The urgent output is high exactly when the pending count is 3 or more and refresh is enabled.
- R6: With deferral disabled, the request is high whenever the pending count is nonzero, whatever the idle input says.
- R7: With deferral enabled and fewer than 3 owed, the request is high only while the idle input is high and the count is nonzero.
- R8: With deferral enabled and 3 or more owed, the request is high even while the idle input is low.
- R9: While the disable input is high, no ticks occur, the pending count holds, and request and urgent stay low. After the disable input falls, the next tick comes a full interval later.
- R10: A completion pulse while the pending count is 0 is ignored and the count stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| intv_sel | input | 2 | Refresh interval code (0 slowest ... 3 fastest) |
| defer_en | input | 1 | Allow refreshes to wait for arbiter idle |
| ref_off | input | 1 | Debug refresh disable, level held externally |
| arb_idle | input | 1 | Arbiter has no memory request in flight |
| ref_done | input | 1 | One-cycle pulse: sequencer completed a refresh |
| ref_req | output | 1 | Refresh requested |
| ref_urgent | output | 1 | Request must preempt memory traffic |
| pend_cnt | output | 3 | Number of refreshes owed (0 to 4) |

## Verification
The hardest state to reach from the ports is a full queue of four owed refreshes hit by one more tick. Reaching it means letting several whole intervals pass with the arbiter reported busy, deferral on and no completions. A second hard case is a tick and a completion landing on the very same edge.

The stimulus works from a table. It holds the fastest interval, keeps the idle input low across enough edges to fill and then overfill the queue, and then drains the queue one completion at a time. A directed step counts edges from reset so that a completion lands exactly on a tick edge. Another directed step counts edges from the fall of the disable input to check the restart of the interval.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  typedef enum logic [1:0] {
    INTV_SLOW   = 2'd0,
    INTV_MIDLO  = 2'd1,
    INTV_MIDHI  = 2'd2,
    INTV_FAST   = 2'd3
  } intv_code_e;
endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer
  import refresh_pkg::*;
#(
  parameter int unsigned LEN_SLOW  = 1560,
  parameter int unsigned LEN_MIDLO = 1170,
  parameter int unsigned LEN_MIDHI = 780,
  parameter int unsigned LEN_FAST  = 390,
  parameter int unsigned TW        = $clog2(LEN_SLOW + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  input  logic       run,
  output logic       tick
);
  logic [TW-1:0] cnt_q, cnt_d, last;

  always_comb begin
    unique case (intv_code_e'(sel))
      INTV_SLOW:  last = TW'(LEN_SLOW - 1);
      INTV_MIDLO: last = TW'(LEN_MIDLO - 1);
      INTV_MIDHI: last = TW'(LEN_MIDHI - 1);
      default:    last = TW'(LEN_FAST - 1);
    endcase
  end

  always_comb begin
    tick  = run && (cnt_q >= last);
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  // R9
  tick_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);
endmodule

// File: rtl/refresh_owed_counter.sv
module refresh_owed_counter #(
  parameter int unsigned MAX_PEND = 4,
  parameter int unsigned CW       = $clog2(MAX_PEND + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          done,
  output logic [CW-1:0] pend
);
  logic [CW-1:0] pend_q, pend_d;
  logic          full, empty, pay;

  always_comb begin
    full   = (pend_q == CW'(MAX_PEND));
    empty  = (pend_q == '0);
    pay    = done && !empty;
    pend_d = pend_q;
    if (tick && !pay && !full)  pend_d = pend_q + 1'b1;
    else if (pay && (!tick || full)) pend_d = pend_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= CW'(MAX_PEND));
  // R10
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !tick && pend_q == '0) |=> pend_q == '0);
  // R3
  pay_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !tick && pend_q != '0) |=> pend_q == $past(pend_q) - 1'b1);
endmodule

// File: rtl/refresh_req_policy.sv
module refresh_req_policy #(
  parameter int unsigned CW     = 3,
  parameter int unsigned URG_TH = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] pend,
  input  logic          defer_en,
  input  logic          arb_idle,
  input  logic          off,
  output logic          req,
  output logic          urgent
);
  logic owed;

  always_comb begin
    owed   = (pend != '0);
    urgent = !off && (pend >= CW'(URG_TH));
    if (off)           req = 1'b0;
    else if (!defer_en) req = owed;
    else               req = urgent || (owed && arb_idle);
  end

  // R8
  urgent_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    urgent |-> req);
  // R9
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off |-> (!req && !urgent));
  // R7
  defer_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (defer_en && !arb_idle && !urgent) |-> !req);
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int unsigned LEN_SLOW  = 1560,
  parameter int unsigned LEN_MIDLO = 1170,
  parameter int unsigned LEN_MIDHI = 780,
  parameter int unsigned LEN_FAST  = 390,
  parameter int unsigned MAX_PEND  = 4,
  parameter int unsigned URG_TH    = 3,
  localparam int unsigned CW       = $clog2(MAX_PEND + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    intv_sel,
  input  logic          defer_en,
  input  logic          ref_off,
  input  logic          arb_idle,
  input  logic          ref_done,
  output logic          ref_req,
  output logic          ref_urgent,
  output logic [CW-1:0] pend_cnt
);
  logic tick;
  logic run;

  assign run = !ref_off;

  refresh_interval_timer #(
    .LEN_SLOW (LEN_SLOW),
    .LEN_MIDLO(LEN_MIDLO),
    .LEN_MIDHI(LEN_MIDHI),
    .LEN_FAST (LEN_FAST)
  ) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .sel  (intv_sel),
    .run  (run),
    .tick (tick)
  );

  refresh_owed_counter #(
    .MAX_PEND(MAX_PEND),
    .CW      (CW)
  ) u_owed (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick),
    .done (ref_done && run),
    .pend (pend_cnt)
  );

  refresh_req_policy #(
    .CW    (CW),
    .URG_TH(URG_TH)
  ) u_policy (
    .clk     (clk),
    .rst_n   (rst_n),
    .pend    (pend_cnt),
    .defer_en(defer_en),
    .arb_idle(arb_idle),
    .off     (ref_off),
    .req     (ref_req),
    .urgent  (ref_urgent)
  );

  // R5
  urgent_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_off && pend_cnt >= CW'(URG_TH)) |-> ref_urgent);
  // R9
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_off && $past(ref_off)) |-> $stable(pend_cnt));
endmodule

// File: tb/refresh_sched_bench.sv
module refresh_sched_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] intv_sel;
  logic       defer_en, ref_off, arb_idle, ref_done;
  logic       ref_req, ref_urgent;
  logic [2:0] pend_cnt;

  int checks = 0;
  int failures = 0;
  bit done_run = 1'b0;

  always #5 clk = ~clk;

  refresh_sched u_refresh_sched (
    .clk(clk), .rst_n(rst_n), .intv_sel(intv_sel), .defer_en(defer_en),
    .ref_off(ref_off), .arb_idle(arb_idle), .ref_done(ref_done),
    .ref_req(ref_req), .ref_urgent(ref_urgent), .pend_cnt(pend_cnt)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] code);
    @(negedge clk);
    rst_n = 1'b0; intv_sel = code; defer_en = 1'b0; ref_off = 1'b0;
    arb_idle = 1'b0; ref_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // fields: wait, defer, idle, done, pend, req, urg
  typedef struct packed {
    logic [11:0] wt;
    logic        df, idl, dn;
    logic [2:0]  pd;
    logic        rq, ug;
  } vec_t;
  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{12'd10,  1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0},
    '{12'd380, 1'b0, 1'b0, 1'b0, 3'd1, 1'b1, 1'b0},
    '{12'd1,   1'b1, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0},
    '{12'd1,   1'b1, 1'b1, 1'b0, 3'd1, 1'b1, 1'b0},
    '{12'd390, 1'b1, 1'b0, 1'b0, 3'd2, 1'b0, 1'b0},
    '{12'd390, 1'b1, 1'b0, 1'b0, 3'd3, 1'b1, 1'b1},
    '{12'd390, 1'b1, 1'b0, 1'b0, 3'd4, 1'b1, 1'b1},
    '{12'd390, 1'b1, 1'b0, 1'b0, 3'd4, 1'b1, 1'b1},
    '{12'd1,   1'b1, 1'b0, 1'b1, 3'd3, 1'b1, 1'b1},
    '{12'd1,   1'b1, 1'b0, 1'b1, 3'd2, 1'b0, 1'b0},
    '{12'd1,   1'b0, 1'b0, 1'b1, 3'd1, 1'b1, 1'b0},
    '{12'd1,   1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0},
    '{12'd1,   1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0}
  };

  initial begin : watchdog
    repeat (60000) @(posedge clk);
    if (!done_run) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int lens [4] = '{1560, 1170, 780, 390};
    int n;
    rst_n = 1'b0; intv_sel = 2'd3; defer_en = 1'b0; ref_off = 1'b0;
    arb_idle = 1'b0; ref_done = 1'b0;
    repeat (2) @(negedge clk);
    // R1: values during reset
    check("R1 pend in reset", pend_cnt, 0);
    check("R1 req in reset", ref_req, 0);
    check("R1 urg in reset", ref_urgent, 0);

    // Table walk, fastest interval (code 3 = 390 clocks)
    do_reset(2'd3);
    @(negedge clk);
    check("R1 pend after release", pend_cnt, 0);
    do_reset(2'd3);
    for (int i = 0; i < NV; i++) begin
      defer_en = VEC[i].df; arb_idle = VEC[i].idl; ref_done = VEC[i].dn;
      @(negedge clk);
      ref_done = 1'b0;
      for (int k = 1; k < int'(VEC[i].wt); k++) @(negedge clk);
      #1;
      // R3 R4 R6 R7 R8 R10 along the table
      check($sformatf("R3/R4/R10 table pend step %0d", i), pend_cnt, VEC[i].pd);
      check($sformatf("R6/R7/R8 table req step %0d", i), ref_req, VEC[i].rq);
      check($sformatf("R5 table urg step %0d", i), ref_urgent, VEC[i].ug);
    end

    // R2: interval length per code
    for (int c = 0; c < 4; c++) begin
      do_reset(2'(c));
      n = 0;
      while (pend_cnt == 0 && n < 2000) begin
        @(negedge clk);
        n++;
      end
      check($sformatf("R2 interval code %0d", c), n, lens[c]);
    end

    // R3: tick and completion on the same edge
    do_reset(2'd3);
    repeat (779) @(negedge clk);
    check("R3 pend before coincident edge", pend_cnt, 1);
    ref_done = 1'b1;
    @(negedge clk);
    ref_done = 1'b0;
    check("R3 tick+done leaves count", pend_cnt, 1);

    // R9: disable holds count, silences outputs, restarts interval
    ref_off = 1'b1;
    repeat (800) @(negedge clk);
    check("R9 pend held while off", pend_cnt, 1);
    check("R9 req low while off", ref_req, 0);
    ref_off = 1'b0;
    repeat (389) @(negedge clk);
    check("R9 no tick before full interval", pend_cnt, 1);
    @(negedge clk);
    check("R9 tick after full interval", pend_cnt, 2);
    check("R5 urg low at two owed", ref_urgent, 0);

    done_run = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule